// File: doc/BRIEF.md
# Branch and Overflow Redirect Controller

This block steers instruction fetch for a five-stage in-order pipeline whose conditional branches resolve in the decode stage. Each cycle it looks at the decode stage's branch flag, the equality result of the register comparator next to the register file, the branch target computed in decode, the sequential fetch address and an overflow flag raised by the execute stage. From these it picks the next PC and tells the pipeline registers which control fields to clear.

A taken branch clears the fetch/decode register to an all-zero no-op, so the one instruction fetched behind the branch becomes a single bubble. An untaken branch lets fetch go on in order. An overflow in execute overrides everything: fetch jumps to a fixed handler vector, and the fetch/decode, decode/execute and execute/memory control fields are all cleared in that cycle. The overflowing instruction therefore writes no register and can be restarted later. On that same cycle the block stores the faulting instruction's PC in an exception PC register and an overflow code in a cause register.

Top module: `pipe_redirect_ctrl`

## Requirements
- R1: While reset (`rst_n` low) is active, and after it, until the first overflow, `epc` reads 0 and `cause` reads 0.
- R2: With no branch and no overflow, `pc_sel` is 0 (sequential), `pc_next` equals `pc_plus4`, and all three flush outputs are low in the same cycle.
- R3: A branch in decode whose comparator reports unequal (`id_branch`=1, `id_regs_eq`=0) behaves like R2: `pc_sel` is 0, `pc_next` is `pc_plus4`, and there is no flush.
- R4: A taken branch (`id_branch`=1, `id_regs_eq`=1) with no overflow gives `pc_sel`=1 and `pc_next`=`id_target`, raises `ifid_flush`, and leaves `idex_flush` and `exmem_flush` low, all in the same cycle.
- R5: `ex_overflow`=1 gives `pc_sel`=2 and `pc_next`=0x4000_0040, and raises `ifid_flush`, `idex_flush` and `exmem_flush` in the same cycle.
- R6: When an overflow and a taken branch occur in the same cycle, the outputs are those of R5.
- R7: At the clock edge that ends an overflow cycle, `epc` loads `ex_pc` and `cause` loads the overflow code 12. Both are visible from the next cycle on.
- R8: In cycles without an overflow, including taken-branch cycles, `epc` and `cause` keep their values.
- R9: `id_regs_eq`=1 with `id_branch`=0 has no effect: the outputs are those of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| id_branch | input | 1 | Instruction in decode is a branch-on-equal |
| id_regs_eq | input | 1 | Decode comparator: the two source registers are equal |
| id_target | input | 32 | Branch target computed in decode |
| pc_plus4 | input | 32 | Sequential fetch address |
| ex_overflow | input | 1 | Arithmetic overflow from the execute stage |
| ex_pc | input | 32 | PC of the instruction in execute |
| pc_sel | output | 2 | Next-PC source: 0 sequential, 1 branch, 2 vector |
| pc_next | output | 32 | Selected next fetch address |
| ifid_flush | output | 1 | Load a no-op into the fetch/decode register |
| idex_flush | output | 1 | Clear the decode/execute control fields |
| exmem_flush | output | 1 | Clear the execute/memory control fields |
| epc | output | 32 | Captured PC of the overflowing instruction |
| cause | output | 5 | Exception cause code |

## Verification
The redirect outputs (`pc_sel`, `pc_next` and the three flushes) come from combinational logic. They are due in the cycle the stimulus is applied, so the bench drives each vector on a falling edge and checks them one time unit later, before any rising edge. `epc` and `cause` pass through one register. They are due one rising edge after an overflow cycle, so the bench checks them at the next falling edge against a model that it updates only when it drives an overflow. For the no-effect and hold cases, the bench looks at the same registered outputs over later cycles.

// File: rtl/redirect_pkg.sv
package redirect_pkg;

  typedef enum logic [1:0] {
    SEL_SEQ    = 2'd0,
    SEL_BRANCH = 2'd1,
    SEL_VECTOR = 2'd2
  } pc_sel_e;

  // A branch is taken only when decode flags a branch and the operands match.
  function automatic logic branch_taken(input logic is_br, input logic eq);
    return is_br & eq;
  endfunction

  // Overflow redirect outranks a taken branch.
  function automatic pc_sel_e choose_sel(input logic ovf, input logic taken);
    if (ovf)        return SEL_VECTOR;
    else if (taken) return SEL_BRANCH;
    else            return SEL_SEQ;
  endfunction

endpackage

// File: rtl/redirect_decide.sv
module redirect_decide
  import redirect_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    id_branch,
  input  logic    id_regs_eq,
  input  logic    ex_overflow,
  output pc_sel_e sel,
  output logic    flush_ifid,
  output logic    flush_idex,
  output logic    flush_exmem
);

  logic taken_w;

  always_comb begin
    taken_w     = branch_taken(id_branch, id_regs_eq);
    sel         = choose_sel(ex_overflow, taken_w);
    flush_ifid  = (sel != SEL_SEQ);
    flush_idex  = (sel == SEL_VECTOR);
    flush_exmem = (sel == SEL_VECTOR);
  end

  AST_TAKEN_ONE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (id_branch && id_regs_eq && !ex_overflow) |-> (flush_ifid && !flush_idex && !flush_exmem)); // R4

  AST_UNTAKEN_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (!(id_branch && id_regs_eq) && !ex_overflow) |-> (!flush_ifid && sel == SEL_SEQ)); // R3

endmodule

// File: rtl/redirect_pc_mux.sv
module redirect_pc_mux
  import redirect_pkg::*;
#(
  parameter int          AW     = 32,
  parameter logic [AW-1:0] VECTOR = 32'h4000_0040
) (
  input  pc_sel_e       sel,
  input  logic [AW-1:0] seq_pc,
  input  logic [AW-1:0] br_pc,
  output logic [AW-1:0] next_pc
);

  always_comb begin
    unique case (sel)
      SEL_BRANCH: next_pc = br_pc;
      SEL_VECTOR: next_pc = VECTOR;
      default:    next_pc = seq_pc;
    endcase
  end

endmodule

// File: rtl/exc_capture.sv
module exc_capture #(
  parameter int          AW   = 32,
  parameter int          CW   = 5,
  parameter logic [CW-1:0] CODE = 5'd12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_exc,
  input  logic [AW-1:0] fault_pc,
  output logic [AW-1:0] epc_q,
  output logic [CW-1:0] cause_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= '0;
    end else if (take_exc) begin
      epc_q   <= fault_pc;
      cause_q <= CODE;
    end
  end

  AST_EPC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |=> (epc_q == $past(fault_pc) && cause_q == CODE)); // R7

  AST_EPC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take_exc |=> ($stable(epc_q) && $stable(cause_q))); // R8

endmodule

// File: rtl/pipe_redirect_ctrl.sv
module pipe_redirect_ctrl
  import redirect_pkg::*;
#(
  parameter int          AW       = 32,
  parameter int          CW       = 5,
  parameter logic [AW-1:0] VECTOR   = 32'h4000_0040,
  parameter logic [CW-1:0] OVF_CODE = 5'd12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          id_branch,
  input  logic          id_regs_eq,
  input  logic [AW-1:0] id_target,
  input  logic [AW-1:0] pc_plus4,
  input  logic          ex_overflow,
  input  logic [AW-1:0] ex_pc,
  output logic [1:0]    pc_sel,
  output logic [AW-1:0] pc_next,
  output logic          ifid_flush,
  output logic          idex_flush,
  output logic          exmem_flush,
  output logic [AW-1:0] epc,
  output logic [CW-1:0] cause
);

  pc_sel_e sel_w;

  redirect_decide u_decide (
    .clk        (clk),
    .rst_n      (rst_n),
    .id_branch  (id_branch),
    .id_regs_eq (id_regs_eq),
    .ex_overflow(ex_overflow),
    .sel        (sel_w),
    .flush_ifid (ifid_flush),
    .flush_idex (idex_flush),
    .flush_exmem(exmem_flush)
  );

  redirect_pc_mux #(.AW(AW), .VECTOR(VECTOR)) u_mux (
    .sel    (sel_w),
    .seq_pc (pc_plus4),
    .br_pc  (id_target),
    .next_pc(pc_next)
  );

  exc_capture #(.AW(AW), .CW(CW), .CODE(OVF_CODE)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .take_exc(ex_overflow),
    .fault_pc(ex_pc),
    .epc_q   (epc),
    .cause_q (cause)
  );

  assign pc_sel = sel_w;

  AST_VECTOR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ex_overflow |-> (pc_next == VECTOR && ifid_flush && idex_flush && exmem_flush)); // R6

  AST_QUIET_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_branch && !ex_overflow) |-> (pc_next == pc_plus4 && !ifid_flush)); // R2

endmodule

// File: tb/tb_pipe_redirect_ctrl.sv
module tb_pipe_redirect_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        id_branch, id_regs_eq, ex_overflow;
  logic [31:0] id_target, pc_plus4, ex_pc;
  logic [1:0]  pc_sel;
  logic [31:0] pc_next, epc;
  logic        ifid_flush, idex_flush, exmem_flush;
  logic [4:0]  cause;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  pipe_redirect_ctrl dut (
    .clk(clk), .rst_n(rst_n), .id_branch(id_branch), .id_regs_eq(id_regs_eq),
    .id_target(id_target), .pc_plus4(pc_plus4), .ex_overflow(ex_overflow),
    .ex_pc(ex_pc), .pc_sel(pc_sel), .pc_next(pc_next), .ifid_flush(ifid_flush),
    .idex_flush(idex_flush), .exmem_flush(exmem_flush), .epc(epc), .cause(cause)
  );

  typedef struct packed {
    logic        br;
    logic        eq;
    logic        ovf;
    logic [31:0] tgt;
    logic [31:0] pc4;
    logic [31:0] xpc;
    logic [1:0]  sel;
    logic [2:0]  fl;   // {ifid, idex, exmem}
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b0, 1'b0, 32'h0000_0100, 32'h0000_0008, 32'h0000_0004, 2'd0, 3'b000}, // R2
    '{1'b1, 1'b0, 1'b0, 32'h0000_0180, 32'h0000_000C, 32'h0000_0008, 2'd0, 3'b000}, // R3
    '{1'b1, 1'b1, 1'b0, 32'h0000_0200, 32'h0000_0010, 32'h0000_000C, 2'd1, 3'b100}, // R4
    '{1'b0, 1'b1, 1'b0, 32'h0000_0300, 32'h0000_0204, 32'h0000_0200, 2'd0, 3'b000}, // R9
    '{1'b0, 1'b0, 1'b1, 32'h0000_0400, 32'h0000_0208, 32'h0000_1000, 2'd2, 3'b111}, // R5
    '{1'b1, 1'b1, 1'b0, 32'h0000_0500, 32'h4000_0044, 32'h0000_2222, 2'd1, 3'b100}, // R8
    '{1'b1, 1'b1, 1'b1, 32'h0000_0600, 32'h0000_0504, 32'h0000_2000, 2'd2, 3'b111}, // R6
    '{1'b0, 1'b0, 1'b0, 32'h0000_0700, 32'h4000_0044, 32'h0000_3333, 2'd0, 3'b000}  // R2
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] m_epc   = '0;
  logic [4:0]  m_cause = '0;

  task automatic check_regs(input string req);
    chk(epc == m_epc, req, epc, m_epc);
    chk(cause == m_cause, req, {27'd0, cause}, {27'd0, m_cause});
  endtask

  task automatic drive(input vec_t v);
    id_branch   = v.br;
    id_regs_eq  = v.eq;
    ex_overflow = v.ovf;
    id_target   = v.tgt;
    pc_plus4    = v.pc4;
    ex_pc       = v.xpc;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(TBL[0]);
    repeat (3) @(negedge clk);
    check_regs("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_regs("R1 after reset");

    for (int i = 0; i < NV; i++) begin
      logic [31:0] exp_pc;
      @(negedge clk);
      check_regs(TBL[i].ovf ? "R7/R8 before vector" : "R8 hold");
      drive(TBL[i]);
      #1;
      exp_pc = (TBL[i].sel == 2'd0) ? TBL[i].pc4 :
               (TBL[i].sel == 2'd1) ? TBL[i].tgt : 32'h4000_0040;
      chk(pc_sel == TBL[i].sel, "R2-R6,R9 pc_sel", {30'd0, pc_sel}, {30'd0, TBL[i].sel});
      chk(pc_next == exp_pc, "R2-R6,R9 pc_next", pc_next, exp_pc);
      chk({ifid_flush, idex_flush, exmem_flush} == TBL[i].fl, "R2-R6,R9 flush",
          {29'd0, ifid_flush, idex_flush, exmem_flush}, {29'd0, TBL[i].fl});
      if (TBL[i].ovf) begin
        m_epc   = TBL[i].xpc;
        m_cause = 5'd12;
      end
    end
    @(negedge clk);
    check_regs("R7 last capture");

    // R7: back-to-back overflows each reload epc
    drive('{1'b0, 1'b0, 1'b1, 32'h0, 32'h0, 32'h0000_AAA0, 2'd2, 3'b111});
    @(negedge clk);
    m_epc = 32'h0000_AAA0;
    check_regs("R7 first of pair");
    drive('{1'b0, 1'b0, 1'b1, 32'h0, 32'h0, 32'h0000_BBB0, 2'd2, 3'b111});
    @(negedge clk);
    m_epc = 32'h0000_BBB0;
    check_regs("R7 second of pair");

    // R8: several quiet and branch cycles leave epc and cause alone
    drive(TBL[2]);
    repeat (3) @(negedge clk);
    check_regs("R8 hold over branches");

    // R1: reset mid-run clears the capture registers
    rst_n = 1'b0;
    @(negedge clk);
    m_epc = '0; m_cause = '0;
    check_regs("R1 reset mid-run");
    rst_n = 1'b1;
    drive(TBL[0]);
    @(negedge clk);
    check_regs("R1 after second reset");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule